// File: doc/BRIEF.md
# Per-Processor Local Interrupt Register Bank

This block keeps the local interrupt state of every virtual processor in a multi-processor interrupt controller: a control word, a local pending vector, a local mask, a compare-interrupt routing word, a redirect pointer and a compare value. A processor reaches the bank through a single-cycle register port that carries its own index. In the local window the access lands in the requester's own bank. In the redirect window it lands in the bank named by the requester's redirect pointer, so one processor can set up another processor's local interrupts.

A compare-match pulse per processor (from an external timer) sets that processor's compare pending bit. The routed compare interrupt is combined with the shared-source router's pins for the same processor before leaving the block, so each processor sees one set of interrupt pins.

Top module: `local_irq_bank`

## Requirements
- R1: After reset every bank reads control 0, pending 0x00, mask 0x32, compare map 0x80000000, compare low 0xFFFFFFFF and redirect pointer 0, and all `vp_pin` outputs are 0.
- R2: A write to the control register (code 0) has no effect: it still reads 0.
- R3: With `req_other`=0 an access targets bank `req_vp`. With `req_other`=1 it targets the bank held in the redirect pointer (code 6) of bank `req_vp`.
- R4: A redirect-pointer write whose data is not less than NUM_VP is ignored, and the pointer keeps its value.
- R5: Reading the ident register (code 7) returns the index of the bank that was addressed.
- R6: The mask (code 2, bits [5:0]) changes only through a set-mask write (code 4, ORs in data[5:0]) or a clear-mask write (code 3, clears the bits set in data[5:0]). Data bits above 5 have no effect.
- R7: A compare-map write (code 5) whose pin field data[5:0] exceeds MAX_PIN is ignored. Otherwise only bit 31 (route flag) and bits [5:0] (pin) are stored, and all other bits read 0.
- R8: A `cmp_hit` pulse sets pending bit 1 of that bank in the next cycle. Output pin p of processor v is driven by the compare interrupt exactly when pending bit 1, mask bit 1 and route flag are all set and the stored pin equals p.
- R9: A compare-low write (code 8) clears pending bit 1 and loads the new compare value. Compare high (code 9) reads 0. If `cmp_hit` arrives in the same cycle as the write, the pending bit ends set.
- R10: `vp_pin[v*NUM_PINS+p]` is the OR of the compare interrupt for (v,p) and `shared_pin[v*NUM_PINS+p]`.
- R11: A read returns its data on `rd_data` with `rd_valid` high one cycle after the request. Codes 3, 4 and codes 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_other | input | 1 | 1 = redirect window, 0 = local window |
| req_vp | input | IDX_W | Index of the requesting processor |
| req_reg | input | 4 | Register code |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| cmp_hit | input | NUM_VP | Compare-match pulse per processor |
| shared_pin | input | NUM_VP*NUM_PINS | Shared-router pins per processor |
| vp_pin | output | NUM_VP*NUM_PINS | Combined interrupt pins per processor |

## Verification
The bench builds the block with NUM_VP=3 and MAX_PIN=5, giving a two-bit processor index with one unused code. Redirect-pointer writes of 3 and above are therefore rejected inside the field width as well as beyond it. Three banks let redirect traffic land in a bank other than the requester's, while a third bank shows it was left untouched. The six pins per processor allow the pin-field rejection at 6 and the highest legal pin 5 to be observed at the outputs.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int DATA_W       = 32;
  localparam int LMASK_W      = 6;
  localparam int CMP_BIT      = 1;
  localparam int MAP_FLAG_BIT = 31;
  localparam int PIN_FLD_W    = 6;
  localparam logic [LMASK_W-1:0] LMASK_RST = 6'h32;
  localparam logic [DATA_W-1:0]  CMAP_RST  = 32'h8000_0000;
  localparam logic [DATA_W-1:0]  CMPV_RST  = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    RG_CTL   = 4'd0,
    RG_PEND  = 4'd1,
    RG_MASK  = 4'd2,
    RG_MCLR  = 4'd3,
    RG_MSET  = 4'd4,
    RG_CMAP  = 4'd5,
    RG_OTHER = 4'd6,
    RG_IDENT = 4'd7,
    RG_CMPLO = 4'd8,
    RG_CMPHI = 4'd9
  } reg_code_e;

  function automatic logic [LMASK_W-1:0] mask_or_in(input logic [LMASK_W-1:0] cur,
                                                    input logic [DATA_W-1:0] d);
    return cur | d[LMASK_W-1:0];
  endfunction

  function automatic logic [LMASK_W-1:0] mask_knock_out(input logic [LMASK_W-1:0] cur,
                                                        input logic [DATA_W-1:0] d);
    return cur & ~d[LMASK_W-1:0];
  endfunction

  function automatic logic cmap_legal(input logic [DATA_W-1:0] d, input int max_pin);
    return {{(DATA_W-PIN_FLD_W){1'b0}}, d[PIN_FLD_W-1:0]} <= DATA_W'(max_pin);
  endfunction

  function automatic logic [DATA_W-1:0] cmap_keep(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] keep;
    keep = '0;
    keep[MAP_FLAG_BIT] = 1'b1;
    keep[PIN_FLD_W-1:0] = '1;
    return d & keep;
  endfunction

  function automatic logic ptr_legal(input logic [DATA_W-1:0] d, input int n);
    return d < DATA_W'(n);
  endfunction
endpackage

// File: rtl/lirq_bank.sv
module lirq_bank
  import lirq_pkg::*;
#(
  parameter int NUM_VP  = 4,
  parameter int MAX_PIN = 5,
  parameter int IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           wr_reg,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 cmp_hit,
  output logic [LMASK_W-1:0]   mask_q,
  output logic [LMASK_W-1:0]   pend_q,
  output logic [DATA_W-1:0]    cmap_q,
  output logic [IDX_W-1:0]     other_q,
  output logic [DATA_W-1:0]    cmp_q,
  output logic                 mask_wr,
  output logic                 cmp_clr,
  output logic                 cmp_req,
  output logic [PIN_FLD_W-1:0] cmp_pin
);
  logic mset_wr, mclr_wr, cmap_wr_ok, ptr_wr_ok;

  assign mset_wr    = wr_en && (wr_reg == RG_MSET);
  assign mclr_wr    = wr_en && (wr_reg == RG_MCLR);
  assign mask_wr    = mset_wr || mclr_wr;
  assign cmap_wr_ok = wr_en && (wr_reg == RG_CMAP) && cmap_legal(wr_data, MAX_PIN);
  assign ptr_wr_ok  = wr_en && (wr_reg == RG_OTHER) && ptr_legal(wr_data, NUM_VP);
  assign cmp_clr    = wr_en && (wr_reg == RG_CMPLO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= LMASK_RST;
      pend_q  <= '0;
      cmap_q  <= CMAP_RST;
      other_q <= '0;
      cmp_q   <= CMPV_RST;
    end else begin
      if (mset_wr)    mask_q <= mask_or_in(mask_q, wr_data);
      if (mclr_wr)    mask_q <= mask_knock_out(mask_q, wr_data);
      if (cmap_wr_ok) cmap_q <= cmap_keep(wr_data);
      if (ptr_wr_ok)  other_q <= wr_data[IDX_W-1:0];
      if (cmp_clr)    cmp_q <= wr_data;
      if (cmp_hit)      pend_q[CMP_BIT] <= 1'b1;
      else if (cmp_clr) pend_q[CMP_BIT] <= 1'b0;
    end
  end

  assign cmp_req = pend_q[CMP_BIT] & mask_q[CMP_BIT] & cmap_q[MAP_FLAG_BIT];
  assign cmp_pin = cmap_q[PIN_FLD_W-1:0];
endmodule

// File: rtl/lirq_route.sv
module lirq_route #(
  parameter int NUM_VP = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_other,
  input  logic [IDX_W-1:0]        req_vp,
  input  logic [NUM_VP*IDX_W-1:0] other_flat,
  output logic [IDX_W-1:0]        tgt_idx,
  output logic                    tgt_ok,
  output logic [NUM_VP-1:0]       wr_sel
);
  logic [IDX_W-1:0] req_ptr;

  always_comb begin
    req_ptr = '0;
    for (int v = 0; v < NUM_VP; v++) begin
      if (req_vp == IDX_W'(v)) req_ptr = other_flat[v*IDX_W +: IDX_W];
    end
  end

  assign tgt_ok  = {{(32-IDX_W){1'b0}}, req_vp} < 32'(NUM_VP);
  assign tgt_idx = req_other ? req_ptr : req_vp;

  for (genvar v = 0; v < NUM_VP; v++) begin : g_sel
    assign wr_sel[v] = req_valid && req_write && tgt_ok && (tgt_idx == IDX_W'(v));
  end
endmodule

// File: rtl/lirq_pin_merge.sv
module lirq_pin_merge #(
  parameter int NUM_PINS  = 6,
  parameter int PIN_FLD_W = 6
) (
  input  logic                 cmp_req,
  input  logic [PIN_FLD_W-1:0] cmp_pin,
  input  logic [NUM_PINS-1:0]  shared_in,
  output logic [NUM_PINS-1:0]  pins
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pins[p] = shared_in[p] | (cmp_req && (cmp_pin == PIN_FLD_W'(p)));
  end
endmodule

// File: rtl/local_irq_bank.sv
module local_irq_bank
  import lirq_pkg::*;
#(
  parameter int NUM_VP  = 4,
  parameter int MAX_PIN = 5,
  localparam int IDX_W    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int NUM_PINS = MAX_PIN + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_other,
  input  logic [IDX_W-1:0]           req_vp,
  input  logic [3:0]                 req_reg,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_VP-1:0]          cmp_hit,
  input  logic [NUM_VP*NUM_PINS-1:0] shared_pin,
  output logic [NUM_VP*NUM_PINS-1:0] vp_pin
);
  logic [IDX_W-1:0]        tgt_idx;
  logic                    tgt_ok;
  logic [NUM_VP-1:0]       wr_sel;
  logic [NUM_VP*IDX_W-1:0] other_flat;
  logic [NUM_VP*LMASK_W-1:0] mask_flat;
  logic [NUM_VP-1:0]       pend_cmp;
  logic [NUM_VP-1:0]       mask_wr_ev;
  logic [NUM_VP-1:0]       cmp_clr_ev;
  logic [NUM_VP*PIN_FLD_W-1:0] cmap_pin_flat;

  logic [LMASK_W-1:0]   mask_a  [NUM_VP];
  logic [LMASK_W-1:0]   pend_a  [NUM_VP];
  logic [DATA_W-1:0]    cmap_a  [NUM_VP];
  logic [IDX_W-1:0]     other_a [NUM_VP];
  logic [DATA_W-1:0]    cmp_a   [NUM_VP];
  logic                 creq_a  [NUM_VP];
  logic [PIN_FLD_W-1:0] cpin_a  [NUM_VP];

  lirq_route #(.NUM_VP(NUM_VP), .IDX_W(IDX_W)) route_i (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_other (req_other),
    .req_vp    (req_vp),
    .other_flat(other_flat),
    .tgt_idx   (tgt_idx),
    .tgt_ok    (tgt_ok),
    .wr_sel    (wr_sel)
  );

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    lirq_bank #(.NUM_VP(NUM_VP), .MAX_PIN(MAX_PIN), .IDX_W(IDX_W)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_sel[v]),
      .wr_reg (req_reg),
      .wr_data(req_wdata),
      .cmp_hit(cmp_hit[v]),
      .mask_q (mask_a[v]),
      .pend_q (pend_a[v]),
      .cmap_q (cmap_a[v]),
      .other_q(other_a[v]),
      .cmp_q  (cmp_a[v]),
      .mask_wr(mask_wr_ev[v]),
      .cmp_clr(cmp_clr_ev[v]),
      .cmp_req(creq_a[v]),
      .cmp_pin(cpin_a[v])
    );

    lirq_pin_merge #(.NUM_PINS(NUM_PINS), .PIN_FLD_W(PIN_FLD_W)) merge_i (
      .cmp_req  (creq_a[v]),
      .cmp_pin  (cpin_a[v]),
      .shared_in(shared_pin[v*NUM_PINS +: NUM_PINS]),
      .pins     (vp_pin[v*NUM_PINS +: NUM_PINS])
    );

    assign other_flat[v*IDX_W +: IDX_W]           = other_a[v];
    assign mask_flat[v*LMASK_W +: LMASK_W]        = mask_a[v];
    assign pend_cmp[v]                            = pend_a[v][CMP_BIT];
    assign cmap_pin_flat[v*PIN_FLD_W +: PIN_FLD_W] = cmap_a[v][PIN_FLD_W-1:0];
  end

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    logic [LMASK_W-1:0] s_mask, s_pend;
    logic [DATA_W-1:0]  s_cmap, s_cmp;
    logic [IDX_W-1:0]   s_other;
    s_mask = '0; s_pend = '0; s_cmap = '0; s_cmp = '0; s_other = '0;
    for (int v = 0; v < NUM_VP; v++) begin
      if (tgt_idx == IDX_W'(v)) begin
        s_mask  = mask_a[v];
        s_pend  = pend_a[v];
        s_cmap  = cmap_a[v];
        s_cmp   = cmp_a[v];
        s_other = other_a[v];
      end
    end
    case (req_reg)
      RG_PEND:  rd_next = {{(DATA_W-LMASK_W){1'b0}}, s_pend};
      RG_MASK:  rd_next = {{(DATA_W-LMASK_W){1'b0}}, s_mask};
      RG_CMAP:  rd_next = s_cmap;
      RG_OTHER: rd_next = {{(DATA_W-IDX_W){1'b0}}, s_other};
      RG_IDENT: rd_next = {{(DATA_W-IDX_W){1'b0}}, tgt_idx};
      RG_CMPLO: rd_next = s_cmp;
      default:  rd_next = '0;
    endcase
    if (!tgt_ok) rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/local_irq_bank_chk.sv
module local_irq_bank_chk
  import lirq_pkg::*;
#(
  parameter int NUM_VP  = 4,
  parameter int MAX_PIN = 5,
  parameter int IDX_W   = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_write,
  input logic [3:0]                    req_reg,
  input logic                          rd_valid,
  input logic [DATA_W-1:0]             rd_data,
  input logic [IDX_W-1:0]              tgt_idx,
  input logic                          tgt_ok,
  input logic [NUM_VP-1:0]             cmp_hit,
  input logic [NUM_VP-1:0]             pend_cmp,
  input logic [NUM_VP-1:0]             mask_wr_ev,
  input logic [NUM_VP-1:0]             cmp_clr_ev,
  input logic [NUM_VP*IDX_W-1:0]       other_flat,
  input logic [NUM_VP*LMASK_W-1:0]     mask_flat,
  input logic [NUM_VP*PIN_FLD_W-1:0]   cmap_pin_flat
);
  // R11: read data arrives one cycle after a read request
  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  // R5: ident readback carries the addressed bank index
  assert_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && tgt_ok && req_reg == RG_IDENT)
      |=> (rd_data == {{(DATA_W-IDX_W){1'b0}}, $past(tgt_idx)}));

  for (genvar v = 0; v < NUM_VP; v++) begin : g_chk
    // R4: redirect pointer never names a missing bank
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(32-IDX_W){1'b0}}, other_flat[v*IDX_W +: IDX_W]} < 32'(NUM_VP)));

    // R6: mask only moves on a mask write
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_ev[v] |=> $stable(mask_flat[v*LMASK_W +: LMASK_W]));

    // R7: stored pin field is always a legal pin
    assert_cmap_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(32-PIN_FLD_W){1'b0}}, cmap_pin_flat[v*PIN_FLD_W +: PIN_FLD_W]} <= 32'(MAX_PIN)));

    // R8: compare match sets pending
    assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[v] |=> pend_cmp[v]);

    // R9: compare-low write without match clears pending
    assert_cmplo_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_clr_ev[v] && !cmp_hit[v]) |=> !pend_cmp[v]);
  end
endmodule

bind local_irq_bank local_irq_bank_chk #(.NUM_VP(NUM_VP), .MAX_PIN(MAX_PIN), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_reg      (req_reg),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .tgt_idx      (tgt_idx),
  .tgt_ok       (tgt_ok),
  .cmp_hit      (cmp_hit),
  .pend_cmp     (pend_cmp),
  .mask_wr_ev   (mask_wr_ev),
  .cmp_clr_ev   (cmp_clr_ev),
  .other_flat   (other_flat),
  .mask_flat    (mask_flat),
  .cmap_pin_flat(cmap_pin_flat)
);

// File: tb/local_irq_bank_tb_top.sv
module local_irq_bank_tb_top;
  localparam int NV = 3;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_other = 1'b0;
  logic [1:0] req_vp = '0;
  logic [3:0] req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NV-1:0] cmp_hit = '0;
  logic [NV*NP-1:0] shared_pin = '0;
  logic [NV*NP-1:0] vp_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  local_irq_bank #(.NUM_VP(NV), .MAX_PIN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_other(req_other), .req_vp(req_vp), .req_reg(req_reg), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmp_hit(cmp_hit),
    .shared_pin(shared_pin), .vp_pin(vp_pin)
  );

  task automatic wr(input int vp, input bit oth, input int rg, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_other = oth; req_vp = 2'(vp);
    req_reg = 4'(rg); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int vp, input bit oth, input int rg, input logic [31:0] e, input string t);
    req_valid = 1; req_write = 0; req_other = oth; req_vp = 2'(vp); req_reg = 4'(rg);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic chk_pins(input logic [NV*NP-1:0] e, input string t);
    checks++;
    if (vp_pin !== e) begin
      errors++;
      $display("FAIL %s: vp_pin actual %h expected %h", t, vp_pin, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected rd_valid, data %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_pins('0, "R1");
    rd(0, 0, 0, 32'h0, "R1");
    rd(0, 0, 1, 32'h0, "R1");
    rd(0, 0, 2, 32'h32, "R1");
    rd(2, 0, 5, 32'h8000_0000, "R1");
    rd(1, 0, 8, 32'hFFFF_FFFF, "R1");
    rd(1, 0, 6, 32'h0, "R1");
    rd(1, 0, 9, 32'h0, "R9");
    // R2 control write ignored
    wr(0, 0, 0, 32'hFFFF_FFFF);
    rd(0, 0, 0, 32'h0, "R2");
    // R5 ident
    rd(1, 0, 7, 32'd1, "R5");
    rd(2, 0, 7, 32'd2, "R5");
    // R4 pointer rejection
    wr(0, 0, 6, 32'd2);
    rd(0, 0, 6, 32'd2, "R4");
    wr(0, 0, 6, 32'd3);
    rd(0, 0, 6, 32'd2, "R4");
    wr(0, 0, 6, 32'd7);
    rd(0, 0, 6, 32'd2, "R4");
    // R3 redirect window
    rd(0, 1, 7, 32'd2, "R3");
    rd(2, 1, 7, 32'd0, "R3");
    wr(0, 1, 4, 32'h01);
    rd(2, 0, 2, 32'h33, "R3");
    rd(0, 0, 2, 32'h32, "R3");
    // R6 mask set / clear on bank 1
    wr(1, 0, 4, 32'hFFFF_FFC0);
    rd(1, 0, 2, 32'h32, "R6");
    wr(1, 0, 4, 32'h0C);
    rd(1, 0, 2, 32'h3E, "R6");
    wr(1, 0, 3, 32'h12);
    rd(1, 0, 2, 32'h2C, "R6");
    wr(1, 0, 3, 32'hFFFF_FFC0);
    rd(1, 0, 2, 32'h2C, "R6");
    wr(1, 0, 2, 32'h00);
    rd(1, 0, 2, 32'h2C, "R6");
    // R7 compare map
    wr(1, 0, 5, 32'h8000_0006);
    rd(1, 0, 5, 32'h8000_0000, "R7");
    wr(1, 0, 5, 32'h0000_0025);
    rd(1, 0, 5, 32'h8000_0000, "R7");
    wr(1, 0, 5, 32'hFFFF_0F03);
    rd(1, 0, 5, 32'h8000_0003, "R7");
    // R8 compare match and routing
    cmp_hit = 3'b010;
    @(negedge clk);
    cmp_hit = '0;
    rd(1, 0, 1, 32'h02, "R8");
    chk_pins('0, "R8");
    wr(1, 0, 4, 32'h02);
    chk_pins(18'(1) << 9, "R8");
    wr(1, 0, 5, 32'h0000_0003);
    chk_pins('0, "R8");
    wr(1, 0, 5, 32'h8000_0005);
    chk_pins(18'(1) << 11, "R8");
    rd(0, 0, 1, 32'h0, "R8");
    // R9 compare-low write
    wr(1, 0, 8, 32'h0000_1234);
    chk_pins('0, "R9");
    rd(1, 0, 1, 32'h0, "R9");
    rd(1, 0, 8, 32'h0000_1234, "R9");
    cmp_hit = 3'b010;
    wr(1, 0, 8, 32'h0000_0055);
    cmp_hit = '0;
    rd(1, 0, 1, 32'h02, "R9");
    rd(1, 0, 8, 32'h0000_0055, "R9");
    chk_pins(18'(1) << 11, "R9");
    // R10 merge with shared router
    shared_pin = 18'h00001;
    @(negedge clk);
    chk_pins(18'h00801, "R10");
    shared_pin = 18'h00800;
    @(negedge clk);
    chk_pins(18'h00800, "R10");
    shared_pin = 18'h20800;
    @(negedge clk);
    chk_pins(18'h20800, "R10");
    shared_pin = '0;
    // R11 unused codes read zero
    rd(1, 0, 3, 32'h0, "R11");
    rd(1, 0, 4, 32'h0, "R11");
    rd(1, 0, 12, 32'h0, "R11");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: outstanding reads actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule